// File: doc/BRIEF.md
# Pulse-Width Infrared Code Receiver

This block turns a demodulated infrared remote signal into a code word. The line idles high and carries information in the length of its low pulses. A frame opens with a long low start pulse. Each following low pulse carries one bit, and its length decides whether the bit is a one or a zero. One timer measures each low pulse in clock cycles. A second timer runs from the falling edge of the start pulse and puts an upper bound on the whole frame.

Data bits arrive least-significant first. A frame closes when the bit budget is full or when the frame timer runs out while the receiver waits for the next pulse. The receiver then presents the right-aligned code and the number of bits it captured, and raises `done`. The consumer reads both outputs and returns a one-cycle `ack_clear`. The receiver then waits for the line to go high before it hunts for the next start pulse.

All thresholds are parameters given in clock cycles. By default they are derived from the clock frequency: the start threshold is 80 % of 2.4 ms, the one-bit threshold is 80 % of 1.2 ms, and the frame bound is 44 ms. The input passes through a synchronizer before the receiver uses it.

Top module: `irpw_rx`

## Requirements
- R1: After reset, `done` is 0 and `code` and `count` are all zeros.
- R2: A start pulse is accepted only if the synchronized line stays low for more than START_CNT consecutive clock cycles. A start pulse of START_CNT cycles or fewer is discarded, and the receiver goes back to hunting for a start pulse.
- R3: A data pulse that stays low for more than ONE_CNT cycles is a 1. A data pulse of ONE_CNT cycles or fewer is a 0.
- R4: The first data bit received lands in `code[0]`, the second in `code[1]`, and so on. Every bit of `code` at position `count` or above is zero.
- R5: The frame closes as soon as the MAX_BITS-th data bit (20 by default) has been captured, and `count` then equals MAX_BITS.
- R6: The frame timer starts at the first low sample of the start pulse. The frame closes when more than FRAME_CNT cycles have passed while the receiver waits for the next data pulse. `count` then holds the number of bits captured so far, which may be zero; with zero bits, `code` is zero.
- R7: When a frame closes, `code` and `count` update together and `done` rises. All three hold their values until `ack_clear` is sampled high, and `done` falls on the following cycle.
- R8: While `done` is high, activity on `ir_n` has no effect. An `ack_clear` pulse while `done` is low also has no effect.
- R9: After an acknowledge, the receiver does not search for a start pulse until it has seen the line high. A line that is already low at acknowledge time never counts as a start pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ir_n | input | 1 | Demodulated infrared line, low while active, asynchronous |
| ack_clear | input | 1 | Consumer pulse that clears `done` |
| done | output | 1 | A frame result is waiting |
| code | output | CODE_W | Right-aligned received code |
| count | output | $clog2(MAX_BITS+1) | Number of bits in `code` |

## Verification
The hardest case to reach from the ports is an acknowledge that arrives while the line is still low. Only this case separates a receiver that first waits for an idle-high line from one that treats the tail of an old pulse as a new start pulse. The bench holds a result pending, then drives the line low and keeps it low well past the start threshold. It acknowledges in the middle of that low stretch and then sends a genuine frame. The scoreboard expects exactly one result. A spurious zero-bit frame caused by timeout would arrive first and not match. Pulses of exactly the threshold length and one cycle longer probe the strict comparisons.

// File: rtl/irpw_pkg.sv
package irpw_pkg;

    typedef enum logic [2:0] {
        ST_REARM  = 3'd0,
        ST_HUNT   = 3'd1,
        ST_START  = 3'd2,
        ST_GAP    = 3'd3,
        ST_BIT    = 3'd4,
        ST_CLOSE  = 3'd5,
        ST_HOLD   = 3'd6
    } rx_state_t;

    localparam int DEF_CODE_W   = 32;
    localparam int DEF_MAX_BITS = 20;

    function automatic int cycles_for_us(input longint hz, input longint us);
        return int'((hz / 64'd1000000) * us);
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/irpw_sync.sv
module irpw_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '1;
        end else begin
            chain <= {chain[STAGES-2:0], async_in};
        end
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/irpw_timer.sv
module irpw_timer #(
    parameter int LIMIT = 100,
    localparam int W = $clog2(LIMIT + 2)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] SAT = W'(LIMIT + 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= inc ? W'(1) : '0;
        end else if (inc && (cnt != SAT)) begin
            cnt <= cnt + W'(1);
        end
    end

    assert_timer_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (!clr && !inc) |=> $stable(cnt));
    assert_timer_restart_R6: assert property (@(posedge clk) disable iff (rst)
        (clr && inc) |=> (cnt == W'(1)));
endmodule

// File: rtl/irpw_fsm.sv
module irpw_fsm
    import irpw_pkg::*;
#(
    parameter int START_CNT = 40,
    parameter int ONE_CNT   = 20,
    parameter int FRAME_CNT = 2000,
    parameter int CODE_W    = 32,
    parameter int MAX_BITS  = 20,
    parameter int BIT_W     = 6,
    parameter int FRM_W     = 11,
    localparam int NB_W     = $clog2(MAX_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_hi,
    input  logic              ack_clear,
    input  logic [BIT_W-1:0]  bit_cnt,
    input  logic [FRM_W-1:0]  frm_cnt,
    output logic              bit_clr,
    output logic              frm_clr,
    output logic              done,
    output logic [CODE_W-1:0] code,
    output logic [NB_W-1:0]   count
);
    localparam int SH_W = $clog2(CODE_W + 1);

    rx_state_t         st;
    logic [CODE_W-1:0] shreg;
    logic [NB_W-1:0]   nbits;

    logic start_ok, bit_is_one, frame_late, last_bit;
    logic [SH_W-1:0] sh_amt;

    always_comb begin
        start_ok   = bit_cnt > BIT_W'(START_CNT);
        bit_is_one = bit_cnt > BIT_W'(ONE_CNT);
        frame_late = frm_cnt > FRM_W'(FRAME_CNT);
        last_bit   = nbits == NB_W'(MAX_BITS - 1);
        sh_amt     = SH_W'(CODE_W) - SH_W'(nbits);
        frm_clr    = (st == ST_HUNT) && !line_hi;
        bit_clr    = ((st == ST_HUNT) || ((st == ST_GAP) && !frame_late)) && !line_hi;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_REARM;
            shreg <= '0;
            nbits <= '0;
            done  <= 1'b0;
            code  <= '0;
            count <= '0;
        end else begin
            unique case (st)
                ST_REARM: if (line_hi) st <= ST_HUNT;
                ST_HUNT:  if (!line_hi) st <= ST_START;
                ST_START: begin
                    if (line_hi) begin
                        if (start_ok) begin
                            shreg <= '0;
                            nbits <= '0;
                            st    <= ST_GAP;
                        end else begin
                            st <= ST_HUNT;
                        end
                    end
                end
                ST_GAP: begin
                    if (frame_late)    st <= ST_CLOSE;
                    else if (!line_hi) st <= ST_BIT;
                end
                ST_BIT: begin
                    if (line_hi) begin
                        shreg <= {bit_is_one, shreg[CODE_W-1:1]};
                        nbits <= nbits + NB_W'(1);
                        st    <= last_bit ? ST_CLOSE : ST_GAP;
                    end
                end
                ST_CLOSE: begin
                    code  <= shreg >> sh_amt;
                    count <= nbits;
                    done  <= 1'b1;
                    st    <= ST_HOLD;
                end
                ST_HOLD: begin
                    if (ack_clear) begin
                        done <= 1'b0;
                        st   <= ST_REARM;
                    end
                end
                default: st <= ST_REARM;
            endcase
        end
    end

    assert_done_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (done && !ack_clear) |=> (done && $stable(code) && $stable(count)));
    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
        (done && ack_clear) |=> !done);
    assert_count_max_R5: assert property (@(posedge clk) disable iff (rst)
        done |-> (count <= NB_W'(MAX_BITS)));
    assert_code_aligned_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> ((code >> count) == '0));
    assert_hold_ignores_line_R8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_HOLD && !ack_clear) |=> (st == ST_HOLD));
    assert_rearm_waits_high_R9: assert property (@(posedge clk) disable iff (rst)
        (st == ST_REARM && !line_hi) |=> (st == ST_REARM));
endmodule

// File: rtl/irpw_rx.sv
module irpw_rx
    import irpw_pkg::*;
#(
    parameter longint CLK_HZ   = 200_000_000,
    parameter int START_CNT    = cycles_for_us(CLK_HZ, 1920),
    parameter int ONE_CNT      = cycles_for_us(CLK_HZ, 960),
    parameter int FRAME_CNT    = cycles_for_us(CLK_HZ, 44000),
    parameter int CODE_W       = DEF_CODE_W,
    parameter int MAX_BITS     = DEF_MAX_BITS,
    parameter int SYNC_STAGES  = 2,
    localparam int NB_W        = $clog2(MAX_BITS + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ir_n,
    input  logic              ack_clear,
    output logic              done,
    output logic [CODE_W-1:0] code,
    output logic [NB_W-1:0]   count
);
    localparam int BIT_LIM = max_int(START_CNT, ONE_CNT);
    localparam int BIT_W   = $clog2(BIT_LIM + 2);
    localparam int FRM_W   = $clog2(FRAME_CNT + 2);

    logic             line_hi;
    logic             bit_clr, frm_clr;
    logic [BIT_W-1:0] bit_cnt;
    logic [FRM_W-1:0] frm_cnt;

    irpw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .async_in(ir_n), .sync_out(line_hi)
    );

    irpw_timer #(.LIMIT(BIT_LIM)) u_bit_tmr (
        .clk(clk), .rst(rst), .clr(bit_clr), .inc(!line_hi), .cnt(bit_cnt)
    );

    irpw_timer #(.LIMIT(FRAME_CNT)) u_frm_tmr (
        .clk(clk), .rst(rst), .clr(frm_clr), .inc(1'b1), .cnt(frm_cnt)
    );

    irpw_fsm #(
        .START_CNT(START_CNT), .ONE_CNT(ONE_CNT), .FRAME_CNT(FRAME_CNT),
        .CODE_W(CODE_W), .MAX_BITS(MAX_BITS), .BIT_W(BIT_W), .FRM_W(FRM_W)
    ) u_fsm (
        .clk(clk), .rst(rst), .line_hi(line_hi), .ack_clear(ack_clear),
        .bit_cnt(bit_cnt), .frm_cnt(frm_cnt),
        .bit_clr(bit_clr), .frm_clr(frm_clr),
        .done(done), .code(code), .count(count)
    );
endmodule

// File: tb/irpw_rx_tb.sv
module irpw_rx_tb;
    localparam int START_CNT = 40;
    localparam int ONE_CNT   = 20;
    localparam int FRAME_CNT = 2000;
    localparam int GAP       = 15;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ir_n = 1'b1;
    logic        ack_clear = 1'b0;
    logic        done;
    logic [31:0] code;
    logic [4:0]  count;

    int n_checks = 0;
    int n_fail   = 0;
    bit auto_ack = 1'b1;
    bit finished = 1'b0;

    logic [31:0] q_code[$];
    int          q_cnt[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    irpw_rx #(.START_CNT(START_CNT), .ONE_CNT(ONE_CNT), .FRAME_CNT(FRAME_CNT)) u_dut (
        .clk(clk), .rst(rst), .ir_n(ir_n), .ack_clear(ack_clear),
        .done(done), .code(code), .count(count)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic pulse(input int lo, input int hi);
        ir_n = 1'b0;
        repeat (lo) @(negedge clk);
        ir_n = 1'b1;
        repeat (hi) @(negedge clk);
    endtask

    task automatic send(input int st_len, input int n, input logic [31:0] pat,
                        input int one_l, input int zero_l, input bit push, input string tag);
        if (push) begin
            q_code.push_back(32'((64'(pat)) & ((64'd1 << n) - 64'd1)));
            q_cnt.push_back(n);
            q_tag.push_back(tag);
        end
        pulse(st_len, GAP);
        for (int i = 0; i < n; i++) pulse(pat[i] ? one_l : zero_l, GAP);
    endtask

    task automatic settle();
        wait (q_code.size() == 0);
        wait (done == 1'b0);
        repeat (10) @(negedge clk);
    endtask

    task automatic manual_ack();
        ack_clear = 1'b1;
        @(negedge clk);
        ack_clear = 1'b0;
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            @(posedge done);
            @(negedge clk);
            if (q_code.size() == 0) begin
                check(1'b0, "R7", "unexpected result", longint'(code), 0);
            end else begin
                logic [31:0] ec;
                int en;
                string et;
                ec = q_code.pop_front();
                en = q_cnt.pop_front();
                et = q_tag.pop_front();
                check(code == ec, et, "code", longint'(code), longint'(ec));
                check(int'(count) == en, et, "count", longint'(count), longint'(en));
            end
            if (auto_ack) begin
                repeat (3) @(negedge clk);
                check(done == 1'b1, "R7", "done held before ack", longint'(done), 1);
                ack_clear = 1'b1;
                @(negedge clk);
                ack_clear = 1'b0;
                check(done == 1'b0, "R7", "done after ack", longint'(done), 0);
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "WATCHDOG", "run hung", 0, 0);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(done == 1'b0, "R1", "done after reset", longint'(done), 0);
        check(code == 32'd0, "R1", "code after reset", longint'(code), 0);
        check(count == 5'd0, "R1", "count after reset", longint'(count), 0);
        repeat (5) @(negedge clk);

        // R3 R4 R6: 12-bit frame closed by timeout
        send(80, 12, 32'h0000_0A5C, 40, 10, 1'b1, "R3_R4_R6 12-bit timeout");
        settle();

        // R2: short start rejected, then a full 20-bit frame (R5)
        pulse(30, GAP);
        send(80, 20, 32'h0005_A3C1, 40, 10, 1'b1, "R2_R5 after short start");
        settle();

        // R2 R3 boundaries: start of exactly START_CNT rejected, START_CNT+1 accepted
        pulse(START_CNT, GAP);
        send(START_CNT + 1, 8, 32'h0000_00B5, ONE_CNT + 1, ONE_CNT, 1'b1, "R2_R3 threshold edges");
        settle();

        // R6: valid start, no data bits
        send(80, 0, 32'h0, 40, 10, 1'b1, "R6 zero-bit frame");
        settle();

        // R5: all ones, 20 bits
        send(60, 20, 32'h000F_FFFF, 30, 8, 1'b1, "R5 all ones");
        settle();

        // R4: all zeros, 5 bits
        send(60, 5, 32'h0, 30, 8, 1'b1, "R4 all zeros");
        settle();

        // R8: line ignored while done is high; stray ack has no effect
        auto_ack = 1'b0;
        send(80, 9, 32'h0000_0133, 40, 10, 1'b1, "R8 held frame");
        wait (q_code.size() == 0);
        @(negedge clk);
        send(80, 20, 32'h000A_AAAA, 40, 10, 1'b0, "");
        check(done == 1'b1, "R8", "done during ignored frame", longint'(done), 1);
        check(code == 32'h133, "R8", "code kept", longint'(code), 32'h133);
        check(count == 5'd9, "R8", "count kept", longint'(count), 9);
        manual_ack();
        check(done == 1'b0, "R7", "done after manual ack", longint'(done), 0);
        repeat (3000) @(negedge clk);
        check(done == 1'b0, "R8", "no result from ignored frame", longint'(done), 0);
        manual_ack();
        repeat (3) @(negedge clk);
        check(done == 1'b0, "R8", "ack with done low", longint'(done), 0);
        check(code == 32'h133, "R8", "code after stray ack", longint'(code), 32'h133);

        // R9: acknowledge while the line is low
        send(80, 6, 32'h0000_0029, 40, 10, 1'b1, "R9 first frame");
        wait (q_code.size() == 0);
        @(negedge clk);
        ir_n = 1'b0;
        repeat (50) @(negedge clk);
        manual_ack();
        repeat (150) @(negedge clk);
        ir_n = 1'b1;
        repeat (20) @(negedge clk);
        check(done == 1'b0, "R9", "no frame from stale low", longint'(done), 0);
        send(80, 7, 32'h0000_0055, 40, 10, 1'b1, "R9 frame after stale low");
        wait (q_code.size() == 0);
        @(negedge clk);
        manual_ack();
        auto_ack = 1'b1;
        repeat (3000) @(negedge clk);

        check(q_code.size() == 0, "R7", "pending expected results", longint'(q_code.size()), 0);
        check(done == 1'b0, "R9", "idle at end", longint'(done), 0);
        finish_run();
    end
endmodule